// File: doc/BRIEF.md
# Upper-Memory Write Protection Checker

This block sits beside the write controller of a 2K x 8 serial EEPROM. For every byte that the controller is about to program, it decides whether that byte may be written. The decision comes from three sources: a protect-enable pin, two block-select pins, and a protection pointer byte. That pointer is held in memory at the top address, and the block keeps a shadow copy of it. Allowed bytes are passed on to the memory array one cycle later. Bytes that fall in the protected range are dropped from the commit. Bus acknowledgement is not touched here.

The protectable region lies in the upper four 256-byte blocks. The block-select pins pick one of these blocks. The upper nibble of the pointer byte places a 16-byte-aligned boundary inside that block. Everything from the boundary up to the top address is protected, and that includes the pointer byte itself. Protection is armed only when the enable pin is high and the pointer's flag bit is zero.

Whenever a byte is committed to the top address, the shadow pointer reloads from that byte. The new setting governs the very next byte. In multibyte mode the check uses the command's start address, so a run that starts just below the boundary carries on into the protected area. In page and single-byte modes, each byte address is checked on its own.

Top module: `upper_wp_checker`

## Requirements
- R1: After reset the shadow pointer holds FFh, so no address is protected even with protEn high, and cmtWe is low.
- R2: blkSel picks the block holding the boundary as block 4 + blkSel: value 0 gives base 400h, 1 gives 500h, 2 gives 600h and 3 gives 700h. Addresses below 400h are never protected.
- R3: When armed, the boundary is the block base plus 16 times pointer bits [7:4]. A checked address at or above the boundary is refused (wrAllow low), and one below it is allowed.
- R4: Pointer bit 2 is an active-low flag, and a 1 there disables protection. Pointer bits 3, 1 and 0 have no effect on the decision.
- R5: With protEn low every address is allowed, including 7FFh.
- R6: While armed, address 7FFh is inside the protected range. A write to it is dropped and the pointer keeps its value.
- R7: A byte presented with byteValid high and allowed appears on cmtWe/cmtAddr/cmtData one cycle later. A refused byte leaves cmtWe low in that cycle.
- R8: A committed byte at 7FFh reloads the shadow pointer, and the new setting governs the next byte.
- R9: With multiMode high the checked address is startAddr. A run starting below the boundary is allowed beyond it, and a run starting at or above the boundary is refused.
- R10: With multiMode low the checked address is byteAddr, whatever startAddr holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protEn | input | 1 | Protect-enable pin |
| blkSel | input | 2 | Selects the upper block that holds the boundary |
| multiMode | input | 1 | 1: check the command start address; 0: check each byte address |
| byteValid | input | 1 | A byte is offered for programming this cycle |
| byteAddr | input | 11 | Address of the offered byte |
| byteData | input | 8 | Data of the offered byte |
| startAddr | input | 11 | Start address of the current write command |
| wrAllow | output | 1 | Combinational decision for the offered byte |
| cmtWe | output | 1 | Registered commit strobe to the array |
| cmtAddr | output | 11 | Committed address |
| cmtData | output | 8 | Committed data |

## Verification
The bench builds the block with its default parameters: 11 address bits, 8 data bits, 256-byte blocks, 16-byte rows and 2 select bits. With these values all four selectable blocks and all sixteen boundaries per block lie within a 2K address space that random addresses cover densely. The directed cases cover the edges of the boundary, the locked top address, the flag and don't-care pointer bits, and the multibyte spill over the boundary. The random traffic also writes the pointer byte itself, so the reloaded settings are exercised under changing pin values.

// File: rtl/upper_wp_pkg.sv
package upper_wp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic commit;   // pass the offered byte to the array
    logic ptrLoad;  // reload the shadow pointer from the offered byte
  } wpStrobe_t;
endpackage

// File: rtl/upper_wp_dpath.sv
module upper_wp_dpath
  import upper_wp_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 8,
  parameter int ROW_W    = 4,
  parameter int SEL_W    = 2,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [SEL_W-1:0]  blkSel,
  output logic              shadowFlag,
  output logic [ADDR_W-1:0] boundAddr,
  output logic              cmtWe,
  output logic [ADDR_W-1:0] cmtAddr,
  output logic [DATA_W-1:0] cmtData
);
  localparam int PTR_W     = BLK_W - ROW_W;
  localparam int BLK_CNT_W = ADDR_W - BLK_W;
  localparam int BASE_BLK  = (1 << BLK_CNT_W) - (1 << SEL_W);

  // only the meaningful pointer bits are kept
  logic [PTR_W-1:0]     ptrHi;
  logic [BLK_CNT_W-1:0] blkIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrHi      <= '1;
      shadowFlag <= 1'b1;
    end else if (strobe.ptrLoad) begin
      ptrHi      <= byteData[DATA_W-1 -: PTR_W];
      shadowFlag <= byteData[FLAG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmtWe   <= 1'b0;
      cmtAddr <= '0;
      cmtData <= '0;
    end else begin
      cmtWe <= strobe.commit;
      if (strobe.commit) begin
        cmtAddr <= byteAddr;
        cmtData <= byteData;
      end
    end
  end

  always_comb begin
    blkIdx    = BLK_CNT_W'(BASE_BLK) + BLK_CNT_W'(blkSel);
    boundAddr = {blkIdx, ptrHi, {ROW_W{1'b0}}};
  end
endmodule

// File: rtl/upper_wp_ctrl.sv
module upper_wp_ctrl
  import upper_wp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              multiMode,
  input  logic              protEn,
  input  logic              shadowFlag,
  input  logic [ADDR_W-1:0] boundAddr,
  output logic              wrAllow,
  output wpStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic              armed;
  logic [ADDR_W-1:0] chkAddr;

  always_comb begin
    armed          = protEn && !shadowFlag;
    chkAddr        = multiMode ? startAddr : byteAddr;
    wrAllow        = !armed || (chkAddr < boundAddr);
    strobe.commit  = byteValid && wrAllow;
    strobe.ptrLoad = byteValid && wrAllow && (byteAddr == TOP_ADDR);
  end
endmodule

// File: rtl/upper_wp_checker.sv
module upper_wp_checker
  import upper_wp_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 8,
  parameter int ROW_W    = 4,
  parameter int SEL_W    = 2,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protEn,
  input  logic [SEL_W-1:0]  blkSel,
  input  logic              multiMode,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              wrAllow,
  output logic              cmtWe,
  output logic [ADDR_W-1:0] cmtAddr,
  output logic [DATA_W-1:0] cmtData
);
  wpStrobe_t         strobe;
  logic              shadowFlag;
  logic [ADDR_W-1:0] boundAddr;

  upper_wp_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .byteValid (byteValid),
    .byteAddr  (byteAddr),
    .startAddr (startAddr),
    .multiMode (multiMode),
    .protEn    (protEn),
    .shadowFlag(shadowFlag),
    .boundAddr (boundAddr),
    .wrAllow   (wrAllow),
    .strobe    (strobe)
  );

  upper_wp_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .ROW_W(ROW_W), .SEL_W(SEL_W), .FLAG_BIT(FLAG_BIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteAddr  (byteAddr),
    .byteData  (byteData),
    .blkSel    (blkSel),
    .shadowFlag(shadowFlag),
    .boundAddr (boundAddr),
    .cmtWe     (cmtWe),
    .cmtAddr   (cmtAddr),
    .cmtData   (cmtData)
  );
endmodule

// File: rtl/upper_wp_sva.sv
module upper_wp_sva #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 8,
  parameter int SEL_W    = 2,
  parameter int FLAG_BIT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              protEn,
  input logic              multiMode,
  input logic              byteValid,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [DATA_W-1:0] byteData,
  input logic [ADDR_W-1:0] startAddr,
  input logic              wrAllow,
  input logic              cmtWe,
  input logic [ADDR_W-1:0] cmtAddr,
  input logic [DATA_W-1:0] cmtData,
  input logic              shadowFlag,
  input logic [ADDR_W-1:0] boundAddr
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
  localparam int                LOW_LIMIT = (1 << ADDR_W) - ((1 << SEL_W) << BLK_W);

  // R2: the lower blocks are never protected
  p_low_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!multiMode && (int'(byteAddr) < LOW_LIMIT)) |-> wrAllow);

  // R3: at or above the boundary is refused when armed
  p_above_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (protEn && !shadowFlag && !multiMode && (byteAddr >= boundAddr)) |-> !wrAllow);

  // R4: the flag bit set disables protection
  p_flag_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    shadowFlag |-> wrAllow);

  // R5: with the enable pin low, everything is allowed
  p_pin_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |-> wrAllow);

  // R6: the top address is locked while armed
  p_top_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (protEn && !shadowFlag && !multiMode && (byteAddr == TOP_ADDR)) |-> !wrAllow);

  // R7: allowed bytes are committed one cycle later
  p_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && wrAllow) |=> (cmtWe && (cmtAddr == $past(byteAddr)) && (cmtData == $past(byteData))));

  // R7: refused bytes are dropped
  p_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !wrAllow) |=> !cmtWe);

  // R8: a commit to the top address reloads the flag
  p_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && wrAllow && (byteAddr == TOP_ADDR)) |=> (shadowFlag == $past(byteData[FLAG_BIT])));

  // R9: in multibyte mode a start below the boundary is allowed
  p_multi_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (multiMode && (startAddr < boundAddr)) |-> wrAllow);
endmodule

bind upper_wp_checker upper_wp_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .SEL_W(SEL_W), .FLAG_BIT(FLAG_BIT)
) sva_i (
  .clk       (clk),
  .rstN      (rstN),
  .protEn    (protEn),
  .multiMode (multiMode),
  .byteValid (byteValid),
  .byteAddr  (byteAddr),
  .byteData  (byteData),
  .startAddr (startAddr),
  .wrAllow   (wrAllow),
  .cmtWe     (cmtWe),
  .cmtAddr   (cmtAddr),
  .cmtData   (cmtData),
  .shadowFlag(shadowFlag),
  .boundAddr (boundAddr)
);

// File: tb/upper_wp_checker_tb_top.sv
module upper_wp_checker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protEn = 1'b0;
  logic [1:0]  blkSel = 2'd0;
  logic        multiMode = 1'b0;
  logic        byteValid = 1'b0;
  logic [10:0] byteAddr = '0;
  logic [7:0]  byteData = '0;
  logic [10:0] startAddr = '0;
  logic        wrAllow;
  logic        cmtWe;
  logic [10:0] cmtAddr;
  logic [7:0]  cmtData;

  int checks = 0;
  int fails = 0;
  logic [7:0] mPtr = 8'hFF;
  bit done = 0;

  always #4 clk = ~clk;

  upper_wp_checker dut_i (
    .clk(clk), .rstN(rstN), .protEn(protEn), .blkSel(blkSel),
    .multiMode(multiMode), .byteValid(byteValid), .byteAddr(byteAddr),
    .byteData(byteData), .startAddr(startAddr), .wrAllow(wrAllow),
    .cmtWe(cmtWe), .cmtAddr(cmtAddr), .cmtData(cmtData)
  );

  function automatic bit modelAllow(logic [10:0] a, logic [10:0] s, bit multi,
                                    bit pe, logic [1:0] sel, logic [7:0] ptr);
    int chk;
    int bound;
    chk = multi ? int'(s) : int'(a);
    if (!pe || ptr[2]) return 1'b1;
    bound = 'h400 + int'(sel) * 256 + int'(ptr[7:4]) * 16;
    return chk < bound;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doByte(string tag, logic [10:0] a, logic [7:0] d, logic [10:0] s,
                        bit multi, bit pe, logic [1:0] sel);
    bit expA;
    @(negedge clk);
    byteValid = 1'b1; byteAddr = a; byteData = d; startAddr = s;
    multiMode = multi; protEn = pe; blkSel = sel;
    expA = modelAllow(a, s, multi, pe, sel, mPtr);
    #1;
    chk({tag, " allow"}, {31'd0, wrAllow}, {31'd0, expA});
    @(negedge clk);
    chk({tag, " R7 we"}, {31'd0, cmtWe}, {31'd0, expA});
    if (expA) begin
      chk({tag, " R7 addr"}, {21'd0, cmtAddr}, {21'd0, a});
      chk({tag, " R7 data"}, {24'd0, cmtData}, {24'd0, d});
      if (a == 11'h7FF) mPtr = d;
    end
    byteValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 cmtWe in reset", {31'd0, cmtWe}, 32'd0);
    rstN = 1'b1;
    // R1: pointer starts at FFh, nothing protected
    doByte("R1 top after reset", 11'h7FF, 8'hFF, 11'h7FF, 0, 1, 2'd3);
    // R5: enable low, load pointer: boundary nibble 3, flag 0
    doByte("R5 load ptr", 11'h7FF, 8'h30, 11'h7FF, 0, 0, 2'd2);
    // R8: next byte already governed by the new setting
    doByte("R8 R3 at bound", 11'h630, 8'h11, 11'h630, 0, 1, 2'd2);
    doByte("R3 below bound", 11'h62F, 8'h12, 11'h62F, 0, 1, 2'd2);
    doByte("R6 top locked", 11'h7FF, 8'h04, 11'h7FF, 0, 1, 2'd2);
    doByte("R2 low block", 11'h3FF, 8'h13, 11'h3FF, 0, 1, 2'd2);
    doByte("R2 sel0 below", 11'h42F, 8'h14, 11'h42F, 0, 1, 2'd0);
    doByte("R2 sel0 at", 11'h430, 8'h15, 11'h430, 0, 1, 2'd0);
    doByte("R2 sel3 at", 11'h730, 8'h16, 11'h730, 0, 1, 2'd3);
    // R9: multibyte spill past the boundary
    doByte("R9 spill", 11'h435, 8'h17, 11'h42F, 1, 1, 2'd0);
    doByte("R9 start inside", 11'h431, 8'h18, 11'h430, 1, 1, 2'd0);
    // R10: per-byte check ignores startAddr
    doByte("R10 page byte", 11'h435, 8'h19, 11'h42F, 0, 1, 2'd0);
    doByte("R10 page low", 11'h42E, 8'h1A, 11'h7FF, 0, 1, 2'd0);
    // R5: enable low allows the protected range and the top
    doByte("R5 pin low", 11'h700, 8'h1B, 11'h700, 0, 0, 2'd0);
    // R4: flag bit 1 disables
    doByte("R4 flag set load", 11'h7FF, 8'h34, 11'h7FF, 0, 0, 2'd0);
    doByte("R4 flag off", 11'h500, 8'h1C, 11'h500, 0, 1, 2'd0);
    // R4: bits 3,1,0 are don't-care
    doByte("R4 dc load", 11'h7FF, 8'h3B, 11'h7FF, 0, 0, 2'd0);
    doByte("R4 dc at", 11'h430, 8'h1D, 11'h430, 0, 1, 2'd0);
    doByte("R4 dc below", 11'h42F, 8'h1E, 11'h42F, 0, 1, 2'd0);
    // random traffic, including pointer writes
    for (int i = 0; i < 600; i++) begin
      logic [10:0] a;
      logic [10:0] s;
      logic [7:0]  d;
      int back;
      a = 11'($urandom_range(0, 2047));
      if ($urandom_range(0, 7) == 0) a = 11'h7FF;
      back = $urandom_range(0, 7);
      s = (int'(a) >= back) ? 11'(int'(a) - back) : 11'd0;
      d = 8'($urandom);
      doByte("R3 R9 R10 random", a, d, s, bit'($urandom_range(0, 1)),
             ($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule